// File: doc/BRIEF.md
# Configuration Access Remap Sequencer

This block carries out a single bus configuration read or write over an address translator that offers too few windows. Only two memory windows exist, so one of them is borrowed for the configuration space and given back afterwards. The caller supplies a bus number, a device slot, a function number, a register offset, an access size and, for writes, the write data.

The sequencer first widens window 0 to 512 MB. Because window 0 wins when windows overlap, the wider window 0 hides window 1. Window 1 is then aimed at the 16 MB configuration aperture with a configuration cycle type. Next the sequencer issues the access at the address it has built. Last, it returns window 1 to a 256 MB prefetchable memory window and shrinks window 0 back to 256 MB. The map register of window 0 is never written.

The translator's registers are written one at a time over a valid/ready port. The access goes out on its own valid/acknowledge port. A single-cycle `done` pulse ends the operation, and for reads it comes with the returned data.

Top module: `cfg_remap_seq`

## Requirements

- R1: After reset, `req_ready` is 1, and `rw_valid`, `acc_valid` and `done` are 0.
- R2: A request is taken only while `req_ready` is 1. `req_ready` stays 0 from that cycle until `done` has been high for exactly one cycle. Request inputs that change while the block is busy have no effect.
- R3: Setup writes come in this order. First, select 0 (window 0 base) gets `{NP_BASE[31:20],12'h0,8'h91}`: size code 9, enabled, not prefetchable. Second, select 1 (window 1 base) gets `{CFG_BASE[31:20],12'h0,8'h41}`: size code 4, enabled. Third, select 2 (window 1 map) gets the built map word in data bits 15:0.
- R4: On bus 0 (type 0), the address holds the function in bits 10:8. A slot of 12 or less sets address bit slot+11. The map word is 16'h000A, which is configuration type 101 in bits 3:1 with bit 0 (low address bits passed through) cleared.
- R5: On bus 0 with a slot from 13 to 20, no select bit appears in the address; map bit slot-5 is set on top of 16'h000A. With a slot from 21 to 31, no select bit appears in either word.
- R6: On any bus other than 0 (type 1), the address is bus<<16 | slot<<11 | function<<8, and the map word is 16'h000B.
- R7: The access goes out only after all three setup writes have been accepted, and before any restore write. Its address is CFG_BASE + built address + offset. Its size code (0 byte, 1 halfword, 2 word), write flag and write data are the ones from the request.
- R8: Restore writes come in this order. First, select 1 gets `{PRE_BASE[31:20],12'h0,8'h89}`: size code 8, prefetchable, enabled. Second, select 2 gets `{PRE_BUS[31:20],4'h6}`, which is memory type 011. Third, select 0 gets `{NP_BASE[31:20],12'h0,8'h81}`.
- R9: Each register write holds its select and data steady until `rw_ready`. With `rw_ready` held high, writes go out one per cycle.
- R10: A read takes `acc_rdata` on its acknowledge and shows it on `rdata` at `done`. A write leaves `rdata` unchanged.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this cycle |
| req_write | input | 1 | 1 for a configuration write |
| req_bus | input | 8 | Bus number |
| req_slot | input | 5 | Device slot |
| req_func | input | 3 | Function number |
| req_offset | input | OFF_W | Register offset within the function |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data |
| rw_valid | output | 1 | Translator register write pending |
| rw_ready | input | 1 | Translator takes the write |
| rw_sel | output | 2 | 0 window 0 base, 1 window 1 base, 2 window 1 map |
| rw_data | output | 32 | Register value |
| acc_valid | output | 1 | Configuration access pending |
| acc_ack | input | 1 | Access completed |
| acc_write | output | 1 | Access direction |
| acc_addr | output | 32 | Access address |
| acc_size | output | 2 | Access size code |
| acc_wdata | output | 32 | Access write data |
| acc_rdata | input | 32 | Read data, valid with acc_ack |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Last read result |

## Verification

The assertions assume two things about the neighbours. The register port and the access port take their transfers in finite time. A neighbour also never expects `rw_data` or `acc_addr` to move while it holds back ready or acknowledge.

The stimulus keeps to this. It draws ready and acknowledge stalls at random but always grants them eventually. It holds `req_valid` high, with scrambled fields, for the whole busy period, so the ignore rule is exercised on every operation. It drops `req_valid` on the `done` cycle.

Slot values are aimed at the 12/13, 20/21 and 31 boundaries. Bus 0 and non-zero buses are both covered, with random slots, functions, offsets and sizes in between.

// File: rtl/cfgremap_pkg.sv
package cfgremap_pkg;

  localparam int WORD_W = 32;
  localparam int BUS_W  = 8;
  localparam int SLOT_W = 5;
  localparam int FN_W   = 3;
  localparam int MAP_W  = 16;
  localparam int SEL_W  = 2;
  localparam int STEP_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ACCESS, ST_RESTORE, ST_DONE
  } seq_state_e;

  typedef enum logic [SEL_W-1:0] {
    RSEL_WIN0_BASE = 2'd0,
    RSEL_WIN1_BASE = 2'd1,
    RSEL_WIN1_MAP  = 2'd2
  } reg_sel_e;

  localparam logic [3:0] SZ_16M  = 4'd4;
  localparam logic [3:0] SZ_256M = 4'd8;
  localparam logic [3:0] SZ_512M = 4'd9;
  localparam logic [2:0] MAP_TYPE_CFG = 3'b101;
  localparam logic [2:0] MAP_TYPE_MEM = 3'b011;

  localparam logic [STEP_W-1:0] LAST_SETUP_STEP   = 3'd2;
  localparam logic [STEP_W-1:0] LAST_RESTORE_STEP = 3'd5;

  // window base word: [31:20] base, [7:4] size code, [3] prefetch, [0] enable
  function automatic logic [WORD_W-1:0] win_word(input logic [11:0] base_hi,
                                                 input logic [3:0] szc,
                                                 input logic pf);
    return {base_hi, 12'h000, szc, pf, 2'b00, 1'b1};
  endfunction

  // map word: [15:4] target address, [3:1] cycle type, [0] low address pass
  function automatic logic [MAP_W-1:0] map_word(input logic [11:0] tgt_hi,
                                                input logic [2:0] ctype,
                                                input logic adlow);
    return {tgt_hi, ctype, adlow};
  endfunction

endpackage

// File: rtl/cfgremap_addr_build.sv
module cfgremap_addr_build
  import cfgremap_pkg::*;
(
  input  logic [BUS_W-1:0]  bus,
  input  logic [SLOT_W-1:0] slot,
  input  logic [FN_W-1:0]   func,
  output logic [WORD_W-1:0] cfg_addr,
  output logic [MAP_W-1:0]  cfg_map
);

  localparam int LOW_SLOT_MAX  = 12;
  localparam int ADDR_SEL_LSB  = 11;
  localparam int MAP_SEL_SHIFT = 5;

  logic                 type1;
  logic [WORD_W-1:0]    onehot_addr;
  logic [MAP_W-1:0]     onehot_map;

  assign type1 = (bus != '0);

  // one-hot device select for slots kept in the address
  always_comb begin
    onehot_addr = '0;
    for (int k = ADDR_SEL_LSB; k <= ADDR_SEL_LSB + LOW_SLOT_MAX; k++) begin
      onehot_addr[k] = (slot == SLOT_W'(k - ADDR_SEL_LSB));
    end
  end

  // one-hot device select for high slots carried in the map word
  always_comb begin
    onehot_map = '0;
    for (int k = LOW_SLOT_MAX + 1 - MAP_SEL_SHIFT; k < MAP_W; k++) begin
      onehot_map[k] = (slot == SLOT_W'(k + MAP_SEL_SHIFT));
    end
  end

  always_comb begin
    if (type1) begin
      cfg_addr = {8'h00, bus, slot, func, 8'h00};
      cfg_map  = map_word(12'h000, MAP_TYPE_CFG, 1'b1);
    end else begin
      cfg_addr = onehot_addr | {21'h0, func, 8'h00};
      cfg_map  = map_word(12'h000, MAP_TYPE_CFG, 1'b0) | onehot_map;
    end
  end

endmodule

// File: rtl/cfgremap_step_table.sv
module cfgremap_step_table
  import cfgremap_pkg::*;
#(
  parameter logic [WORD_W-1:0] NP_BASE  = 32'h4000_0000,
  parameter logic [WORD_W-1:0] PRE_BASE = 32'h5000_0000,
  parameter logic [WORD_W-1:0] PRE_BUS  = 32'h5000_0000,
  parameter logic [WORD_W-1:0] CFG_BASE = 32'h6100_0000
) (
  input  logic [STEP_W-1:0] step,
  input  logic [MAP_W-1:0]  cfg_map,
  output logic [SEL_W-1:0]  sel,
  output logic [WORD_W-1:0] data
);

  localparam logic [WORD_W-1:0] W0_WIDE   = win_word(NP_BASE[31:20], SZ_512M, 1'b0);
  localparam logic [WORD_W-1:0] W1_CFG    = win_word(CFG_BASE[31:20], SZ_16M, 1'b0);
  localparam logic [WORD_W-1:0] W1_PRE    = win_word(PRE_BASE[31:20], SZ_256M, 1'b1);
  localparam logic [MAP_W-1:0]  M1_PRE    = map_word(PRE_BUS[31:20], MAP_TYPE_MEM, 1'b0);
  localparam logic [WORD_W-1:0] W0_NARROW = win_word(NP_BASE[31:20], SZ_256M, 1'b0);

  always_comb begin
    unique case (step)
      3'd0: begin sel = RSEL_WIN0_BASE; data = W0_WIDE; end
      3'd1: begin sel = RSEL_WIN1_BASE; data = W1_CFG; end
      3'd2: begin sel = RSEL_WIN1_MAP;  data = {16'h0000, cfg_map}; end
      3'd3: begin sel = RSEL_WIN1_BASE; data = W1_PRE; end
      3'd4: begin sel = RSEL_WIN1_MAP;  data = {16'h0000, M1_PRE}; end
      3'd5: begin sel = RSEL_WIN0_BASE; data = W0_NARROW; end
      default: begin sel = RSEL_WIN0_BASE; data = '0; end
    endcase
  end

endmodule

// File: rtl/cfg_remap_seq.sv
module cfg_remap_seq
  import cfgremap_pkg::*;
#(
  parameter logic [31:0] NP_BASE  = 32'h4000_0000,
  parameter logic [31:0] PRE_BASE = 32'h5000_0000,
  parameter logic [31:0] PRE_BUS  = 32'h5000_0000,
  parameter logic [31:0] CFG_BASE = 32'h6100_0000,
  parameter int          OFF_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [7:0]        req_bus,
  input  logic [4:0]        req_slot,
  input  logic [2:0]        req_func,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rw_valid,
  input  logic              rw_ready,
  output logic [1:0]        rw_sel,
  output logic [31:0]       rw_data,
  output logic              acc_valid,
  input  logic              acc_ack,
  output logic              acc_write,
  output logic [31:0]       acc_addr,
  output logic [1:0]        acc_size,
  output logic [31:0]       acc_wdata,
  input  logic [31:0]       acc_rdata,
  output logic              done,
  output logic [31:0]       rdata
);

  seq_state_e          state;
  logic [STEP_W-1:0]   step;
  logic [MAP_W-1:0]    map_q;
  logic [WORD_W-1:0]   built_addr;
  logic [MAP_W-1:0]    built_map;
  logic                take_req;
  logic                rw_fire;

  cfgremap_addr_build u_build (
    .bus      (req_bus),
    .slot     (req_slot),
    .func     (req_func),
    .cfg_addr (built_addr),
    .cfg_map  (built_map)
  );

  cfgremap_step_table #(
    .NP_BASE  (NP_BASE),
    .PRE_BASE (PRE_BASE),
    .PRE_BUS  (PRE_BUS),
    .CFG_BASE (CFG_BASE)
  ) u_table (
    .step    (step),
    .cfg_map (map_q),
    .sel     (rw_sel),
    .data    (rw_data)
  );

  assign req_ready = (state == ST_IDLE);
  assign rw_valid  = (state == ST_SETUP) || (state == ST_RESTORE);
  assign acc_valid = (state == ST_ACCESS);
  assign done      = (state == ST_DONE);
  assign take_req  = req_valid && req_ready;
  assign rw_fire   = rw_valid && rw_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      step  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (take_req) begin
          state <= ST_SETUP;
          step  <= '0;
        end
        ST_SETUP: if (rw_fire) begin
          step <= step + 1'b1;
          if (step == LAST_SETUP_STEP) state <= ST_ACCESS;
        end
        ST_ACCESS: if (acc_ack) state <= ST_RESTORE;
        ST_RESTORE: if (rw_fire) begin
          if (step == LAST_RESTORE_STEP) state <= ST_DONE;
          else step <= step + 1'b1;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // request capture
  always_ff @(posedge clk) begin
    if (rst) begin
      map_q     <= '0;
      acc_addr  <= '0;
      acc_write <= 1'b0;
      acc_size  <= '0;
      acc_wdata <= '0;
    end else if (take_req) begin
      map_q     <= built_map;
      acc_addr  <= CFG_BASE + built_addr + WORD_W'(req_offset);
      acc_write <= req_write;
      acc_size  <= req_size;
      acc_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (acc_valid && acc_ack && !acc_write) rdata <= acc_rdata;
  end

  // R9
  rw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rw_valid && !rw_ready |=> rw_valid && $stable(rw_sel) && $stable(rw_data));

  // R7
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_ack |=> acc_valid && $stable(acc_addr) && $stable(acc_write));

  // R7
  rw_acc_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rw_valid && acc_valid));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && req_ready);

  // R2
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (rw_valid || acc_valid) |-> !req_ready);

  // R3
  first_write_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> rw_valid && rw_sel == RSEL_WIN0_BASE);

endmodule

// File: tb/tb_cfg_remap_seq.sv
module tb_cfg_remap_seq;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] NPB = 32'h4000_0000;
  localparam logic [31:0] PRB = 32'h5000_0000;
  localparam logic [31:0] PBU = 32'h5000_0000;
  localparam logic [31:0] CFB = 32'h6100_0000;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_bus = 0;
  logic [4:0] req_slot = 0;
  logic [2:0] req_func = 0;
  logic [7:0] req_offset = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_wdata = 0;
  logic rw_ready = 0, acc_ack = 0;
  logic [31:0] acc_rdata = 0;
  logic req_ready, rw_valid, acc_valid, acc_write, done;
  logic [1:0] rw_sel, acc_size;
  logic [31:0] rw_data, acc_addr, acc_wdata, rdata;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] exp_rdata = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_remap_seq dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] e_addr(input logic [7:0] b, input logic [4:0] s, input logic [2:0] f);
    logic [31:0] a;
    if (b == 0) begin
      a = {21'h0, f, 8'h0};
      if (s <= 12) a = a | (32'h1 << (s + 11));
    end else a = {8'h0, b, s, f, 8'h0};
    return a;
  endfunction

  function automatic logic [15:0] e_map(input logic [7:0] b, input logic [4:0] s);
    logic [15:0] m;
    if (b != 0) return 16'h000B;
    m = 16'h000A;
    if (s >= 13 && s <= 20) m = m | (16'h1 << (s - 5));
    return m;
  endfunction

  task automatic txn(input logic [7:0] b, input logic [4:0] s, input logic [2:0] f,
                     input logic [7:0] off, input logic [1:0] sz, input bit we,
                     input logic [31:0] wd, input logic [31:0] rd, input bit stall);
    logic [1:0]  rs [6];
    logic [31:0] rdv [6];
    logic [1:0]  xs [6];
    logic [31:0] xd [6];
    int nw = 0, nacc = 0, lim = 0;
    bit fin = 0;
    xs[0] = 0; xd[0] = {NPB[31:20], 12'h0, 8'h91};
    xs[1] = 1; xd[1] = {CFB[31:20], 12'h0, 8'h41};
    xs[2] = 2; xd[2] = {16'h0, e_map(b, s)};
    xs[3] = 1; xd[3] = {PRB[31:20], 12'h0, 8'h89};
    xs[4] = 2; xd[4] = {16'h0, PBU[31:20], 4'h6};
    xs[5] = 0; xd[5] = {NPB[31:20], 12'h0, 8'h81};
    @(negedge clk);
    chk(req_ready == 1, "R2 idle before request", {31'h0, req_ready}, 32'h1);
    req_bus = b; req_slot = s; req_func = f; req_offset = off;
    req_size = sz; req_write = we; req_wdata = wd; req_valid = 1;
    @(negedge clk);
    // R2: scramble request fields while busy, they must have no effect
    req_bus = ~b; req_slot = ~s; req_func = ~f; req_offset = ~off;
    req_size = ~sz; req_write = ~we; req_wdata = ~wd;
    while (!fin && lim < 200) begin
      rw_ready = stall ? 1'($urandom % 2) : 1'b1;
      acc_ack  = stall ? 1'($urandom % 2) : 1'b1;
      acc_rdata = rd;
      #1;
      if (rw_valid || acc_valid)
        chk(req_ready == 0, "R2 busy ready low", {31'h0, req_ready}, 32'h0);
      if (rw_valid && rw_ready) begin
        if (nw < 6) begin rs[nw] = rw_sel; rdv[nw] = rw_data; end
        nw++;
      end
      if (acc_valid && acc_ack) begin
        chk(nw == 3, "R7 access after setup", nw, 3);
        chk(acc_addr == CFB + e_addr(b, s, f) + {24'h0, off}, "R7 access address (R4 R5 R6)",
            acc_addr, CFB + e_addr(b, s, f) + {24'h0, off});
        chk(acc_size == sz && acc_write == we, "R7 size and direction",
            {29'h0, acc_write, acc_size}, {29'h0, we, sz});
        if (we) chk(acc_wdata == wd, "R7 write data", acc_wdata, wd);
        nacc++;
      end
      if (done) begin
        fin = 1;
        req_valid = 0;
        if (!we) exp_rdata = rd;
        chk(nw == 6 && nacc == 1, "R2 counts at done", nw * 16 + nacc, 32'h61);
        chk(rdata == exp_rdata, "R10 rdata", rdata, exp_rdata);
      end
      @(negedge clk);
      lim++;
    end
    chk(fin, "R2 completion", {31'h0, fin}, 32'h1);
    rw_ready = 0; acc_ack = 0;
    #1;
    chk(!done && req_ready, "R2 done single cycle", {30'h0, done, req_ready}, 32'h1);
    for (int i = 0; i < 6 && i < nw; i++) begin
      chk(rs[i] == xs[i], (i < 3) ? "R3 setup select" : "R8 restore select", {30'h0, rs[i]}, {30'h0, xs[i]});
      chk(rdv[i] == xd[i], (i < 3) ? "R3 setup data (R4 R5 R6 map)" : "R8 restore data", rdv[i], xd[i]);
    end
  endtask

  initial begin
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    errors++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    // R1
    chk(req_ready && !rw_valid && !acc_valid && !done, "R1 reset state",
        {28'h0, req_ready, rw_valid, acc_valid, done}, 32'h8);
    // R9 back-to-back writes with no stall
    txn(8'd0, 5'd0, 3'd0, 8'h00, 2'd2, 1'b0, 32'h0, 32'hCAFE_0001, 1'b0);
    // R4 boundary slot 12
    txn(8'd0, 5'd12, 3'd7, 8'h3C, 2'd0, 1'b1, 32'h1234_5678, 32'h0, 1'b1);
    // R5 slots 13, 20, 21, 31
    txn(8'd0, 5'd13, 3'd1, 8'h04, 2'd1, 1'b0, 32'h0, 32'hBEEF_0013, 1'b1);
    txn(8'd0, 5'd20, 3'd2, 8'h10, 2'd2, 1'b0, 32'h0, 32'hBEEF_0020, 1'b0);
    txn(8'd0, 5'd21, 3'd3, 8'h08, 2'd2, 1'b1, 32'hAAAA_5555, 32'h0, 1'b1);
    txn(8'd0, 5'd31, 3'd0, 8'hFC, 2'd0, 1'b0, 32'h0, 32'h0000_0031, 1'b1);
    // R6 type 1
    txn(8'd1, 5'd31, 3'd7, 8'hFF, 2'd0, 1'b0, 32'h0, 32'h7777_0001, 1'b1);
    txn(8'd255, 5'd5, 3'd2, 8'h40, 2'd2, 1'b1, 32'hDEAD_BEEF, 32'h0, 1'b0);
    // R10 write leaves rdata unchanged (checked inside by exp_rdata)
    for (int n = 0; n < 40; n++) begin
      logic [7:0] b;
      b = ($urandom % 2) ? 8'd0 : 8'($urandom);
      txn(b, 5'($urandom), 3'($urandom), 8'($urandom), 2'($urandom % 3),
          1'($urandom), $urandom, $urandom, 1'($urandom));
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule